// File: doc/BRIEF.md
# Video Controller Host Command and Data Port

This block is the host-facing port logic of a tile-based video controller. The host writes 16-bit words to a control port. Each word is either a one-word register write or one half of a two-word access command. An access command carries a 5-bit access code and a 16-bit address, and these are split across the two words. A pending-half flag records that a first half has arrived and that the next control word completes the command.

Once a command is set up, host accesses to the data port go to one of three internal memories, chosen by the access code:

- video RAM, with word width 16 and a parameterised depth;
- colour RAM, 64 words;
- vertical-scroll RAM, 40 words.

After each recognised access the address moves forward by the auto-increment register (register 15).

The block also returns a status word built from DMA state and the horizontal position. It raises a one-cycle DMA start pulse with a mode value; the DMA transfer itself is done elsewhere. The renderer reads the 32 configuration registers through a select port and reads colour RAM expanded to 24-bit colour through a palette port.

Top module: `vport_top`

## Requirements
- R1: After reset, all 32 registers read 0, no first half is pending, the access code and address are 0, `dataRdData` is 0 and `dmaStart` is 0.
- R2: With no half pending, a control word with bits 15:14 equal to 2'b10 writes bits 7:0 into the register selected by bits 12:8, and leaves nothing pending. `regVal` shows register `regSel` combinationally.
- R3: With no half pending, any other control word is a first half. It sets code[1:0] from word[15:14] and address[13:0] from word[13:0], and marks a half pending. The next control word is always a second half, whatever its top bits are. It sets code[4:2] from word[6:4] and address[15:14] from word[1:0], and clears the pending mark.
- R4: A second half with bit 7 set, while register 1 bit 4 is 1, gives `dmaStart` high for exactly the cycle after that write. In that cycle `dmaMode` equals register 23 bits 7:6, with 0 replaced by 1. Otherwise no pulse occurs.
- R5: A data write, data read or status read clears a pending first half.
- R6: Code[3:0]=1 writes video RAM at word index address[VRAM_AW:1], and swaps the two bytes when address bit 0 is 1. Code[3:0]=0 reads that word with no swap.
- R7: Code[3:0]=3 writes colour RAM and code[3:0]=8 reads it, both at word index address[6:1].
- R8: Code[3:0]=5 writes vertical-scroll RAM at index address[6:1], but only when address[6:0] < 80. Code[3:0]=4 reads that RAM, and returns 0 when address[6:0] >= 80.
- R9: After a recognised access, the address advances as follows. For video RAM it becomes address + register 15, modulo 2^16. For colour RAM and vertical-scroll RAM it becomes (address[6:0] + register 15) mod 128, with bits 15:7 cleared. Writes with any other code are ignored and do not advance the address. Reads with any other code return 0 and do not advance the address.
- R10: `statusWord` bit 1 equals `dmaActive` AND NOT `dmaAwaitFill`. Bit 2 is 1 when `hPos` >= 0xE4 or `hPos` < 0x08. All other bits are 0.
- R11: `palRgb` for colour RAM entry `palIdx` is built as follows: bits 23:21 hold entry bits 11:9, bits 15:13 hold entry bits 7:5, bits 7:5 hold entry bits 3:1, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrlWrEn | input | 1 | Control-port write strobe (has priority over data and status strobes) |
| ctrlWrData | input | 16 | Control-port write word |
| dataWrEn | input | 1 | Data-port write strobe |
| dataWrData | input | 16 | Data-port write word |
| dataRdEn | input | 1 | Data-port read strobe |
| dataRdData | output | 16 | Read result, registered, valid the cycle after `dataRdEn` |
| statRdEn | input | 1 | Status read strobe |
| statusWord | output | 16 | Status word |
| hPos | input | 8 | Horizontal position counter |
| dmaActive | input | 1 | DMA engine is running |
| dmaAwaitFill | input | 1 | DMA engine is waiting for fill data |
| dmaStart | output | 1 | One-cycle DMA start pulse |
| dmaMode | output | 2 | DMA mode captured at start |
| regSel | input | 5 | Register select for the renderer |
| regVal | output | 8 | Selected register value |
| palIdx | input | 6 | Colour RAM index for the renderer |
| palRgb | output | 24 | Expanded 24-bit colour |

## Verification
A wrong pending flag shows up on the next control word. A register write is then taken as a second half, so the register read port does not change, or the address lands in the wrong place. A corrupted access code or address shows up on the next data read, which returns the wrong word or a stray zero. A bad advance step or a missing 7-bit wrap shows up on the read that follows. Memory mismatches are caught by a reference model that is compared on every read and on every palette lookup. Each fault therefore appears within one or two port operations.

// File: rtl/vport_pkg.sv
package vport_pkg;
  localparam int REG_NUM     = 32;
  localparam int REG_AW      = $clog2(REG_NUM);
  localparam int CODE_W      = 5;
  localparam int ADDR_W      = 16;
  localparam int NARROW_W    = 7;
  localparam int CRAM_WORDS  = 64;
  localparam int VSRAM_BYTES = 80;
  localparam int VSRAM_WORDS = VSRAM_BYTES / 2;

  localparam logic [REG_AW-1:0] REG_MODE2  = 5'd1;
  localparam int                MODE2_DMA  = 4;
  localparam logic [REG_AW-1:0] REG_STEP   = 5'd15;
  localparam logic [REG_AW-1:0] REG_DMACFG = 5'd23;

  localparam logic [3:0] CODE_VRAM_RD  = 4'd0;
  localparam logic [3:0] CODE_VRAM_WR  = 4'd1;
  localparam logic [3:0] CODE_CRAM_WR  = 4'd3;
  localparam logic [3:0] CODE_VSRAM_RD = 4'd4;
  localparam logic [3:0] CODE_VSRAM_WR = 4'd5;
  localparam logic [3:0] CODE_CRAM_RD  = 4'd8;

  typedef struct packed {
    logic              vramWr;
    logic              cramWr;
    logic              vsramWr;
    logic              vramRd;
    logic              cramRd;
    logic              vsramRd;
    logic              nullRd;
    logic [ADDR_W-1:0] addr;
  } accStrobe_t;
endpackage

// File: rtl/vport_ctrl.sv
module vport_ctrl
  import vport_pkg::*;
#(
  parameter logic [7:0] HBL_START = 8'hE4,
  parameter logic [7:0] HBL_END   = 8'h08,
  parameter int STAT_BUSY_BIT     = 1,
  parameter int STAT_HBL_BIT      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrlWrEn,
  input  logic [15:0]       ctrlWrData,
  input  logic              dataWrEn,
  input  logic              dataRdEn,
  input  logic              statRdEn,
  input  logic [7:0]        hPos,
  input  logic              dmaActive,
  input  logic              dmaAwaitFill,
  input  logic [REG_AW-1:0] regSel,
  output logic [7:0]        regVal,
  output logic [15:0]       statusWord,
  output accStrobe_t        strobe,
  output logic              pendingFlag,
  output logic              dmaStart,
  output logic [1:0]        dmaMode
);
  logic [7:0]          regFile [REG_NUM];
  logic [CODE_W-1:0]   code;
  logic [ADDR_W-1:0]   addr;
  logic                pending;
  logic [7:0]          step;
  logic [1:0]          cfgMode;
  logic                dmaEnabled;
  logic                advance;
  logic                narrow;
  logic [NARROW_W-1:0] narrowSum;
  logic [ADDR_W-1:0]   nextAddr;
  logic                anyAccess;
  logic                unusedCode;

  assign step        = regFile[REG_STEP];
  assign cfgMode     = regFile[REG_DMACFG][7:6];
  assign dmaEnabled  = regFile[REG_MODE2][MODE2_DMA];
  assign regVal      = regFile[regSel];
  assign pendingFlag = pending;
  assign unusedCode  = code[CODE_W-1];
  assign anyAccess   = dataWrEn | dataRdEn | statRdEn;

  always_comb begin
    strobe      = '0;
    strobe.addr = addr;
    if (!ctrlWrEn && dataWrEn) begin
      case (code[3:0])
        CODE_VRAM_WR:  strobe.vramWr  = 1'b1;
        CODE_CRAM_WR:  strobe.cramWr  = 1'b1;
        CODE_VSRAM_WR: strobe.vsramWr = 1'b1;
        default: ;
      endcase
    end else if (!ctrlWrEn && dataRdEn) begin
      case (code[3:0])
        CODE_VRAM_RD:  strobe.vramRd  = 1'b1;
        CODE_CRAM_RD:  strobe.cramRd  = 1'b1;
        CODE_VSRAM_RD: strobe.vsramRd = 1'b1;
        default:       strobe.nullRd  = 1'b1;
      endcase
    end
  end

  assign narrow    = strobe.cramWr | strobe.cramRd | strobe.vsramWr | strobe.vsramRd;
  assign advance   = narrow | strobe.vramWr | strobe.vramRd;
  assign narrowSum = addr[NARROW_W-1:0] + step[NARROW_W-1:0];
  assign nextAddr  = narrow ? {{(ADDR_W-NARROW_W){1'b0}}, narrowSum}
                            : addr + {{(ADDR_W-8){1'b0}}, step};

  always_comb begin
    statusWord                = '0;
    statusWord[STAT_BUSY_BIT] = dmaActive & ~dmaAwaitFill;
    statusWord[STAT_HBL_BIT]  = (hPos >= HBL_START) || (hPos < HBL_END);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      code     <= '0;
      addr     <= '0;
      dmaStart <= 1'b0;
      dmaMode  <= 2'd0;
      for (int i = 0; i < REG_NUM; i++) regFile[i] <= 8'd0;
    end else begin
      dmaStart <= 1'b0;
      if (ctrlWrEn) begin
        if (!pending) begin
          if (ctrlWrData[15:14] == 2'b10) begin
            regFile[ctrlWrData[12:8]] <= ctrlWrData[7:0];
          end else begin
            code[1:0]  <= ctrlWrData[15:14];
            addr[13:0] <= ctrlWrData[13:0];
            pending    <= 1'b1;
          end
        end else begin
          code[4:2]   <= ctrlWrData[6:4];
          addr[15:14] <= ctrlWrData[1:0];
          pending     <= 1'b0;
          if (ctrlWrData[7] && dmaEnabled) begin
            dmaStart <= 1'b1;
            dmaMode  <= (cfgMode == 2'd0) ? 2'd1 : cfgMode;
          end
        end
      end else if (anyAccess) begin
        pending <= 1'b0;
        if (advance) addr <= nextAddr;
      end
    end
  end
endmodule

// File: rtl/vport_datapath.sv
module vport_datapath
  import vport_pkg::*;
#(
  parameter int VRAM_AW = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  accStrobe_t strobe,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic [5:0]  palIdx,
  output logic [23:0] palRgb
);
  localparam int VRAM_WORDS = 1 << VRAM_AW;
  localparam int CRAM_AW    = $clog2(CRAM_WORDS);
  localparam int VSRAM_AW   = $clog2(VSRAM_WORDS);

  logic [15:0] vram  [VRAM_WORDS];
  logic [15:0] cram  [CRAM_WORDS];
  logic [15:0] vsram [VSRAM_WORDS];

  logic [VRAM_AW-1:0]  vIdx;
  logic [CRAM_AW-1:0]  cIdx;
  logic [VSRAM_AW-1:0] sIdx;
  logic                vsInRange;
  logic [15:0]         vramWord;
  logic [15:0]         palEntry;
  logic                unusedAddr;

  assign vIdx       = strobe.addr[VRAM_AW:1];
  assign cIdx       = strobe.addr[CRAM_AW:1];
  assign sIdx       = strobe.addr[VSRAM_AW:1];
  assign vsInRange  = strobe.addr[NARROW_W-1:0] < NARROW_W'(VSRAM_BYTES);
  assign vramWord   = strobe.addr[0] ? {wrData[7:0], wrData[15:8]} : wrData;
  assign unusedAddr = ^strobe.addr[ADDR_W-1:VRAM_AW+1];

  always_ff @(posedge clk) begin
    if (strobe.vramWr) vram[vIdx] <= vramWord;
    if (strobe.cramWr) cram[cIdx] <= wrData;
    if (strobe.vsramWr && vsInRange) vsram[sIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= 16'd0;
    end else if (strobe.vramRd) begin
      rdData <= vram[vIdx];
    end else if (strobe.cramRd) begin
      rdData <= cram[cIdx];
    end else if (strobe.vsramRd) begin
      rdData <= vsInRange ? vsram[sIdx] : 16'd0;
    end else if (strobe.nullRd) begin
      rdData <= 16'd0;
    end
  end

  assign palEntry = cram[palIdx];

  genvar ch;
  generate
    for (ch = 0; ch < 3; ch++) begin : g_chan
      assign palRgb[ch*8 +: 8] = {palEntry[ch*4+1 +: 3], 5'b00000};
    end
  endgenerate
endmodule

// File: rtl/vport_top.sv
module vport_top
  import vport_pkg::*;
#(
  parameter int         VRAM_AW       = 10,
  parameter logic [7:0] HBL_START     = 8'hE4,
  parameter logic [7:0] HBL_END       = 8'h08,
  parameter int         STAT_BUSY_BIT = 1,
  parameter int         STAT_HBL_BIT  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrlWrEn,
  input  logic [15:0] ctrlWrData,
  input  logic        dataWrEn,
  input  logic [15:0] dataWrData,
  input  logic        dataRdEn,
  output logic [15:0] dataRdData,
  input  logic        statRdEn,
  output logic [15:0] statusWord,
  input  logic [7:0]  hPos,
  input  logic        dmaActive,
  input  logic        dmaAwaitFill,
  output logic        dmaStart,
  output logic [1:0]  dmaMode,
  input  logic [4:0]  regSel,
  output logic [7:0]  regVal,
  input  logic [5:0]  palIdx,
  output logic [23:0] palRgb
);
  accStrobe_t strobe;
  logic       pendingFlag;

  vport_ctrl #(
    .HBL_START(HBL_START), .HBL_END(HBL_END),
    .STAT_BUSY_BIT(STAT_BUSY_BIT), .STAT_HBL_BIT(STAT_HBL_BIT)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .dataWrEn(dataWrEn), .dataRdEn(dataRdEn), .statRdEn(statRdEn),
    .hPos(hPos), .dmaActive(dmaActive), .dmaAwaitFill(dmaAwaitFill),
    .regSel(regSel), .regVal(regVal), .statusWord(statusWord),
    .strobe(strobe), .pendingFlag(pendingFlag),
    .dmaStart(dmaStart), .dmaMode(dmaMode)
  );

  vport_datapath #(.VRAM_AW(VRAM_AW)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(dataWrData),
    .rdData(dataRdData), .palIdx(palIdx), .palRgb(palRgb)
  );
endmodule

// File: rtl/vport_checker.sv
module vport_checker (
  input logic        clk,
  input logic        rst,
  input logic        ctrlWrEn,
  input logic [15:0] ctrlWrData,
  input logic        dataWrEn,
  input logic        dataRdEn,
  input logic        statRdEn,
  input logic        pendingFlag,
  input logic        dmaStart,
  input logic [1:0]  dmaMode
);
  p_regwr_leaves_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrlWrEn && !pendingFlag && ctrlWrData[15:14] == 2'b10) |=> !pendingFlag);

  p_first_half_pends_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrlWrEn && !pendingFlag && ctrlWrData[15:14] != 2'b10) |=> pendingFlag);

  p_second_half_closes_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrlWrEn && pendingFlag) |=> !pendingFlag);

  p_access_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctrlWrEn && (dataWrEn || dataRdEn || statRdEn)) |=> !pendingFlag);

  p_dma_needs_second_r4: assert property (@(posedge clk) disable iff (rst)
    dmaStart |-> $past(ctrlWrEn && pendingFlag && ctrlWrData[7]));

  p_dma_mode_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    dmaStart |-> dmaMode != 2'd0);

  p_dma_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    dmaStart |=> !dmaStart);
endmodule

bind vport_top vport_checker u_chk (.*);

// File: tb/tb_vport_top.sv
module tb_vport_top;
  localparam int VAW = 10;
  localparam int VW  = 1 << VAW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrlWrEn = 1'b0, dataWrEn = 1'b0, dataRdEn = 1'b0, statRdEn = 1'b0;
  logic [15:0] ctrlWrData = '0, dataWrData = '0;
  logic [15:0] dataRdData, statusWord;
  logic [7:0]  hPos = 8'h50;
  logic        dmaActive = 1'b0, dmaAwaitFill = 1'b0;
  logic        dmaStart;
  logic [1:0]  dmaMode;
  logic [4:0]  regSel = '0;
  logic [7:0]  regVal;
  logic [5:0]  palIdx = '0;
  logic [23:0] palRgb;

  vport_top #(.VRAM_AW(VAW)) dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [15:0] mVram [VW];
  logic [15:0] mCram [64];
  logic [15:0] mVsram [40];
  logic [7:0]  mReg [32];
  logic        mPend = 1'b0;
  logic [4:0]  mCode = '0;
  logic [15:0] mAddr = '0;
  logic        expStart;
  logic [1:0]  expMode;
  logic        sawStart;
  logic [1:0]  sawMode;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void stepAddr(input logic isNarrow);
    logic [6:0] t;
    if (isNarrow) begin
      t = mAddr[6:0] + mReg[15][6:0];
      mAddr = {9'd0, t};
    end else begin
      mAddr = mAddr + {8'd0, mReg[15]};
    end
  endfunction

  function automatic void mCtrl(input logic [15:0] w);
    expStart = 1'b0;
    if (!mPend) begin
      if (w[15:14] == 2'b10) mReg[w[12:8]] = w[7:0];
      else begin
        mCode[1:0] = w[15:14]; mAddr[13:0] = w[13:0]; mPend = 1'b1;
      end
    end else begin
      mCode[4:2] = w[6:4]; mAddr[15:14] = w[1:0]; mPend = 1'b0;
      if (w[7] && mReg[1][4]) begin
        expStart = 1'b1;
        expMode  = (mReg[23][7:6] == 2'd0) ? 2'd1 : mReg[23][7:6];
      end
    end
  endfunction

  function automatic void mWrite(input logic [15:0] d);
    mPend = 1'b0;
    case (mCode[3:0])
      4'd1: begin mVram[mAddr[VAW:1]] = mAddr[0] ? {d[7:0], d[15:8]} : d; stepAddr(1'b0); end
      4'd3: begin mCram[mAddr[6:1]] = d; stepAddr(1'b1); end
      4'd5: begin if (mAddr[6:0] < 7'd80) mVsram[mAddr[6:1]] = d; stepAddr(1'b1); end
      default: ;
    endcase
  endfunction

  function automatic logic [15:0] mRead();
    logic [15:0] v;
    mPend = 1'b0;
    case (mCode[3:0])
      4'd0: begin v = mVram[mAddr[VAW:1]]; stepAddr(1'b0); end
      4'd4: begin v = (mAddr[6:0] < 7'd80) ? mVsram[mAddr[6:1]] : 16'd0; stepAddr(1'b1); end
      4'd8: begin v = mCram[mAddr[6:1]]; stepAddr(1'b1); end
      default: v = 16'd0;
    endcase
    return v;
  endfunction

  function automatic logic [23:0] expRgb(input logic [15:0] e);
    return {e[11:9], 5'd0, e[7:5], 5'd0, e[3:1], 5'd0};
  endfunction

  task automatic ctrlWrite(input logic [15:0] w);
    @(negedge clk); ctrlWrEn = 1'b1; ctrlWrData = w;
    @(negedge clk); ctrlWrEn = 1'b0;
    mCtrl(w);
    sawStart = dmaStart; sawMode = dmaMode;
  endtask

  task automatic setReg(input logic [4:0] idx, input logic [7:0] val);
    ctrlWrite({3'b100, idx, val});
  endtask

  task automatic setCmd(input logic [4:0] code, input logic [15:0] addr, input logic dmaBit = 1'b0);
    ctrlWrite({code[1:0], addr[13:0]});
    ctrlWrite({8'd0, dmaBit, code[4:2], 2'b00, addr[15:14]});
  endtask

  task automatic dataWrite(input logic [15:0] d);
    @(negedge clk); dataWrEn = 1'b1; dataWrData = d;
    @(negedge clk); dataWrEn = 1'b0;
    mWrite(d);
  endtask

  task automatic dataRead(input string req);
    logic [15:0] e;
    @(negedge clk); dataRdEn = 1'b1;
    @(negedge clk); dataRdEn = 1'b0;
    e = mRead();
    check(req, dataRdData, e);
  endtask

  task automatic statusRead();
    @(negedge clk); statRdEn = 1'b1;
    @(negedge clk); statRdEn = 1'b0;
    mPend = 1'b0;
  endtask

  task automatic checkReg(input string req, input logic [4:0] idx);
    regSel = idx; #1;
    check(req, regVal, mReg[idx]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [4:0] codes [11];
    codes = '{5'd0, 5'd1, 5'd3, 5'd4, 5'd5, 5'd8, 5'd16, 5'd17, 5'd20, 5'd24, 5'd9};
    void'($urandom(32'd7));
    for (int i = 0; i < 32; i++) mReg[i] = 8'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdData", dataRdData, 16'd0);
    check("R1 dmaStart", dmaStart, 1'b0);
    checkReg("R1 reg15", 5'd15);
    checkReg("R1 reg1", 5'd1);
    check("R10 idle status", statusWord, 16'd0);

    setReg(5'd15, 8'd2);
    checkReg("R1/R2 first word is register write", 5'd15);
    setCmd(5'd1, 16'h0000);
    for (int i = 0; i < VW; i++) dataWrite(16'($urandom));
    setCmd(5'd3, 16'h0000);
    for (int i = 0; i < 64; i++) dataWrite(16'($urandom));
    setCmd(5'd5, 16'h0000);
    for (int i = 0; i < 40; i++) dataWrite(16'($urandom));

    // R2 register write
    setReg(5'd7, 8'h5A);
    checkReg("R2 reg7", 5'd7);

    // R6 odd address swap
    setReg(5'd15, 8'd0);
    setCmd(5'd1, 16'h0011);
    dataWrite(16'h1234);
    setCmd(5'd0, 16'h0010);
    dataRead("R6 swapped vram word");
    check("R6 literal swap", dataRdData, 16'h3412);

    // R7 / R11 colour RAM
    setCmd(5'd3, 16'h00C6);
    dataWrite(16'h0A4C);
    setCmd(5'd8, 16'h0046);
    dataRead("R7 cram masked");
    check("R7 literal", dataRdData, 16'h0A4C);
    palIdx = 6'h23; #1;
    check("R11 palette", palRgb, 24'hA040C0);

    // R8 vertical scroll range
    setCmd(5'd5, 16'h0050);
    dataWrite(16'hBEEF);
    setCmd(5'd4, 16'h0050);
    dataRead("R8 out of range reads zero");
    check("R8 literal zero", dataRdData, 16'd0);
    setCmd(5'd4, 16'h004E);
    dataRead("R8 last entry");

    // R9 wrap and unknown codes
    setReg(5'd15, 8'd4);
    setCmd(5'd4, 16'h007E);
    dataRead("R9 vsram at 7E");
    dataRead("R9 vsram wrapped to 02");
    setCmd(5'd8, 16'h007C);
    dataRead("R9 cram at 7C");
    dataRead("R9 cram wrapped to 00");
    setCmd(5'd9, 16'h0020);
    dataWrite(16'hDEAD);
    dataRead("R9 unknown code reads zero");
    setCmd(5'd0, 16'h0020);
    dataRead("R9 unknown write ignored");

    // R3 second half absorbs register-format word
    ctrlWrite(16'h4000);
    ctrlWrite(16'h8711);
    checkReg("R3 second half not a register write", 5'd7);
    // R5 pending cleared by status and data accesses
    ctrlWrite(16'h4000);
    statusRead();
    setReg(5'd7, 8'h33);
    checkReg("R5 status read clears pending", 5'd7);
    ctrlWrite(16'h4000);
    dataRead("R5 read with half pending");
    setReg(5'd7, 8'h44);
    checkReg("R5 data read clears pending", 5'd7);
    ctrlWrite(16'h4000);
    dataWrite(16'h0000);
    setReg(5'd7, 8'h55);
    checkReg("R5 data write clears pending", 5'd7);

    // R4 DMA start
    setReg(5'd1, 8'h10);
    setReg(5'd23, 8'h00);
    setCmd(5'd1, 16'h0000, 1'b1);
    check("R4 start pulse", sawStart, 1'b1);
    check("R4 mode zero->1", sawMode, 2'd1);
    @(negedge clk);
    check("R4 pulse one cycle", dmaStart, 1'b0);
    setReg(5'd23, 8'hC0);
    setCmd(5'd1, 16'h0000, 1'b1);
    check("R4 start pulse mode3", sawStart, 1'b1);
    check("R4 mode3", sawMode, 2'd3);
    setReg(5'd1, 8'h00);
    setCmd(5'd1, 16'h0000, 1'b1);
    check("R4 no start when disabled", sawStart, expStart);

    // R10 status
    foreach (codes[k]) begin
      logic [7:0] hp;
      logic [15:0] e;
      hp = (k == 0) ? 8'hE3 : (k == 1) ? 8'hE4 : (k == 2) ? 8'hFF :
           (k == 3) ? 8'h00 : (k == 4) ? 8'h07 : (k == 5) ? 8'h08 : 8'($urandom);
      hPos = hp; dmaActive = k[0]; dmaAwaitFill = k[1];
      #1;
      e = '0;
      e[1] = dmaActive & ~dmaAwaitFill;
      e[2] = (hp >= 8'hE4) || (hp < 8'h08);
      check("R10 status", statusWord, e);
    end

    // Random mix against the model (R6 R7 R8 R9 R11)
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: setCmd(codes[$urandom % 11], 16'($urandom));
        1: dataWrite(16'($urandom));
        2: dataRead("R9 random read");
        3: setReg(5'd15, 8'($urandom));
        4: begin
             palIdx = 6'($urandom); #1;
             check("R11 random palette", palRgb, expRgb(mCram[palIdx]));
           end
        default: dataRead("R6 random read");
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule